// File: doc/BRIEF.md
# Truncation Error-Tolerant Adder

This block adds two unsigned operands and accepts a small error in exchange for a short carry path. The operand width is split in two. The upper, exact section adds its bits with a normal ripple carry chain and produces a carry-out. The lower, approximate section never forms a carry.

In the lower section a control chain runs from that section's most significant bit down to bit 0. While no position has yet seen two set input bits, each sum bit is the XOR of its two operand bits. At the first position from the top where both inputs are 1, the control goes high. It stays high for that position and every position below it, and all of those sum bits are forced to 1. No carry crosses from the lower section into the upper one; the upper chain starts with a carry-in of 0.

The total width and the width of the lower section are parameters. A lower width of 0 gives an exact adder. The sum and the carry-out are registered, so each result appears one clock after its operands are presented.

Top module: `tea_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_o` and `carry_o` are 0 after that edge, whatever the operands are.
- R2: After each edge without reset, `{carry_o, sum_o[W-1:LW]}` equals `op_a[W-1:LW] + op_b[W-1:LW]` from the operands sampled at that edge. The lower section contributes no carry to this sum.
- R3: In the lower section, every sum bit above the highest position `p` (with `p < LW`) where both operand bits are 1 equals the XOR of its two operand bits.
- R4: In the lower section, sum bits `p` down to 0 are all 1, where `p` is that highest position where both operand bits are 1.
- R5: When no position below `LW` has both operand bits set, `sum_o[LW-1:0]` equals `op_a[LW-1:0] ^ op_b[LW-1:0]`.
- R6: With `LW = 0`, `{carry_o, sum_o}` equals the exact sum `op_a + op_b` for every operand pair.
- R7: A new result appears exactly one rising edge after its operands are applied. Before that edge, the outputs still show the previous result.
- R8: With `LW = W`, `carry_o` is always 0 and every sum bit follows the rules of R3 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| sum_o | output | W | Registered approximate sum |
| carry_o | output | 1 | Registered carry-out of the exact upper section |

## Verification
Every result of this block, both the sum bits and the carry-out, is due exactly one rising edge after the operands are applied. The bench therefore drives operands on the falling edge and compares the outputs 2 ns after the next rising edge. This gives one fresh result per cycle, so one small configuration of each shape can be swept through every operand pair. A separate check samples the outputs between the falling edge and the following rising edge to confirm that the old result is still held there. The reset check applies nonzero operands, so an output that ignored reset would be seen.

// File: rtl/tea_pkg.sv
package tea_pkg;
  // default geometry of the adder
  parameter int unsigned TEA_W_DEF  = 32;
  parameter int unsigned TEA_LW_DEF = 20;

  // width of the exact upper section for a given split
  function automatic int unsigned tea_hi_width(input int unsigned w, input int unsigned lw);
    return (lw >= w) ? 0 : (w - lw);
  endfunction
endpackage

// File: rtl/tea_ripple.sv
// Exact ripple-carry section; carry-in is fixed at zero.
module tea_ripple #(
  parameter int unsigned N = 12
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] s,
  output logic         co
);
  logic [N:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_fa
    logic hp;
    assign hp     = a[i] ^ b[i];
    assign s[i]   = hp ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & hp);
  end

  assign co = c[N];
endmodule

// File: rtl/tea_ctrl_chain.sv
// Downward control chain: a bit goes high at the first 1-1 pair seen
// from the top of the section and stays high for all lower bits.
module tea_ctrl_chain #(
  parameter int unsigned N = 20
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] ctl
);
  logic [N:0] trig;

  assign trig[N] = 1'b0;

  for (genvar i = N - 1; i >= 0; i--) begin : g_link
    assign trig[i] = trig[i+1] | (a[i] & b[i]);
    assign ctl[i]  = trig[i];
  end
endmodule

// File: rtl/tea_carryfree.sv
// Carry-free sum bits: XOR when the control is low, forced one when high.
module tea_carryfree #(
  parameter int unsigned N = 20
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] ctl,
  output logic [N-1:0] s
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign s[i] = ctl[i] ? 1'b1 : (a[i] ^ b[i]);
  end
endmodule

// File: rtl/tea_adder.sv
module tea_adder #(
  parameter int unsigned W  = tea_pkg::TEA_W_DEF,
  parameter int unsigned LW = tea_pkg::TEA_LW_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  localparam int unsigned HW = tea_pkg::tea_hi_width(W, LW);

  logic [W-1:0] sum_c;
  logic         carry_c;

  if (LW > 0) begin : g_lo
    logic [LW-1:0] ctl;

    tea_ctrl_chain #(.N(LW)) u_ctrl (
      .a  (op_a[LW-1:0]),
      .b  (op_b[LW-1:0]),
      .ctl(ctl)
    );

    tea_carryfree #(.N(LW)) u_cf (
      .a  (op_a[LW-1:0]),
      .b  (op_b[LW-1:0]),
      .ctl(ctl),
      .s  (sum_c[LW-1:0])
    );
  end

  if (HW > 0) begin : g_hi
    tea_ripple #(.N(HW)) u_rca (
      .a (op_a[W-1:LW]),
      .b (op_b[W-1:LW]),
      .s (sum_c[W-1:LW]),
      .co(carry_c)
    );
  end else begin : g_nohi
    assign carry_c = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      sum_o   <= sum_c;
      carry_o <= carry_c;
    end
  end
endmodule

// File: rtl/tea_adder_chk.sv
module tea_adder_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = 20
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] sum_o,
  input logic         carry_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && !carry_o));

  if (LW < W) begin : g_hi
    // R2 R6
    exact_upper_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ({carry_o, sum_o[W-1:LW]} ==
                ({1'b0, $past(op_a[W-1:LW])} + {1'b0, $past(op_b[W-1:LW])})));
  end else begin : g_nohi
    // R8
    no_carry_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> !carry_o);
  end

  if (LW > 0) begin : g_lo
    // R4
    forced_lsb_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && (|(op_a[LW-1:0] & op_b[LW-1:0]))) |=> sum_o[0]);
    // R5
    plain_xor_chk: assert property (@(posedge clk) disable iff (rst)
      (!rst && ((op_a[LW-1:0] & op_b[LW-1:0]) == '0)) |=>
        (sum_o[LW-1:0] == $past(op_a[LW-1:0] ^ op_b[LW-1:0])));
  end
endmodule

bind tea_adder tea_adder_chk #(.W(W), .LW(LW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_a   (op_a),
  .op_b   (op_b),
  .sum_o  (sum_o),
  .carry_o(carry_o)
);

// File: tb/sim_tea_adder.sv
module sim_tea_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  // u0: default 32/20
  logic [31:0] a0 = '0, b0 = '0, s0;
  logic        c0;
  // u1: 8 bits, 3 approximate
  logic [7:0]  a1 = '0, b1 = '0, s1;
  logic        c1;
  // u2: 6 bits, exact
  logic [5:0]  a2 = '0, b2 = '0, s2;
  logic        c2;
  // u3: 4 bits, fully approximate
  logic [3:0]  a3 = '0, b3 = '0, s3;
  logic        c3;

  tea_adder #(.W(32), .LW(20)) u0 (.clk(clk), .rst(rst), .op_a(a0), .op_b(b0), .sum_o(s0), .carry_o(c0));
  tea_adder #(.W(8),  .LW(3))  u1 (.clk(clk), .rst(rst), .op_a(a1), .op_b(b1), .sum_o(s1), .carry_o(c1));
  tea_adder #(.W(6),  .LW(0))  u2 (.clk(clk), .rst(rst), .op_a(a2), .op_b(b2), .sum_o(s2), .carry_o(c2));
  tea_adder #(.W(4),  .LW(4))  u3 (.clk(clk), .rst(rst), .op_a(a3), .op_b(b3), .sum_o(s3), .carry_o(c3));

  // reference: returns {carry, sum} in bits [w:0]
  function automatic logic [63:0] ref_add(input logic [63:0] a, input logic [63:0] b,
                                          input int w, input int lw);
    logic [63:0] hi, lo, mask;
    logic trig;
    mask = (64'd1 << (w - lw)) - 64'd1;
    hi = ((a >> lw) & mask) + ((b >> lw) & mask);
    lo = '0;
    trig = 1'b0;
    for (int i = lw - 1; i >= 0; i--) begin
      if (a[i] && b[i]) trig = 1'b1;
      lo[i] = trig ? 1'b1 : (a[i] ^ b[i]);
    end
    return (hi << lw) | lo;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // split comparison for an instance with an upper and a lower section
  task automatic chk_split(input string nm, input logic [63:0] got, input logic [63:0] exp,
                           input logic [63:0] a, input logic [63:0] b, input int lw);
    logic [63:0] lm;
    lm = (64'd1 << lw) - 64'd1;
    chk({nm, " R2"}, got >> lw, exp >> lw);
    if (((a & b) & lm) == 0) chk({nm, " R5"}, got & lm, exp & lm);
    else                     chk({nm, " R3 R4"}, got & lm, exp & lm);
  endtask

  task automatic check_all();
    chk_split("u0", {31'd0, c0, s0}, ref_add(64'(a0), 64'(b0), 32, 20), 64'(a0), 64'(b0), 20);
    chk_split("u1", {55'd0, c1, s1}, ref_add(64'(a1), 64'(b1), 8, 3), 64'(a1), 64'(b1), 3);
    chk("u2 R6", {57'd0, c2, s2}, 64'(a2) + 64'(b2));
    chk("u3 R8", {59'd0, c3, s3}, ref_add(64'(a3), 64'(b3), 4, 4));
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    check_all();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        bad++;
        total++;
        $display("FAIL watchdog got=%0d exp<=200000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset with nonzero operands
    a0 = 32'hFFFF_FFFF; b0 = 32'h1234_5678;
    a1 = 8'hFF; b1 = 8'h0F; a2 = 6'h3F; b2 = 6'h01; a3 = 4'hF; b3 = 4'h3;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 u0", {31'd0, c0, s0}, 64'd0);
    chk("R1 u1", {55'd0, c1, s1}, 64'd0);
    chk("R1 u2", {57'd0, c2, s2}, 64'd0);
    chk("R1 u3", {59'd0, c3, s3}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    step();

    // R7: latency, using the exact instance
    @(negedge clk);
    a2 = 6'd10; b2 = 6'd5;
    step();
    @(negedge clk);
    a2 = 6'd33; b2 = 6'd40;
    #1;
    chk("R7 hold", {57'd0, c2, s2}, 64'd15);
    @(posedge clk);
    #2;
    chk("R7 update", {57'd0, c2, s2}, 64'd73);

    // exhaustive sweep of the small configurations, random on u0
    for (int k = 0; k < 65536; k++) begin
      @(negedge clk);
      a1 = k[15:8]; b1 = k[7:0];
      a2 = k[11:6]; b2 = k[5:0];
      a3 = k[7:4];  b3 = k[3:0];
      a0 = $urandom; b0 = $urandom;
      step();
    end

    // u0 corners: zeros, ones, one 1-1 pair per position
    @(negedge clk); a0 = '0; b0 = '0; step();
    @(negedge clk); a0 = '1; b0 = '1; step();
    chk("u0 ones R2", {31'd0, c0, s0} >> 20, 64'h1FFE);
    chk("u0 ones R4", 64'(s0[19:0]), 64'hFFFFF);
    for (int p = 0; p < 32; p++) begin
      @(negedge clk);
      a0 = 32'd1 << p; b0 = 32'd1 << p;
      step();
    end
    // pair at the top of the lower section plus XOR bits
    @(negedge clk); a0 = 32'h0008_A000; b0 = 32'h0008_5001; step();
    chk("u0 top pair R4", 64'(s0[19:0]), 64'hFFFFF);

    // R1 again mid-run
    @(negedge clk);
    rst = 1'b1;
    a0 = 32'hDEAD_BEEF; b0 = 32'hCAFE_F00D;
    @(posedge clk); #2;
    chk("R1 mid", {31'd0, c0, s0}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule